// File: doc/BRIEF.md
# Minimal 16-bit Harvard Controller Core with Blocking Receive-Byte Instruction

This block is a small, non-pipelined 16-bit processor for firmware that handles a serial bus interface at packet level. It fetches 16-bit instructions from its own instruction memory port and reads and writes a separate data memory port. Any peripheral registers, such as a received packet identifier, sit in the data address space and are reached with ordinary loads and stores. The core has four 16-bit general registers and eleven instructions. Each instruction takes one fetch clock and one execute clock.

One instruction, the receive-byte instruction, takes a byte from an external receive FIFO. If the FIFO is empty, the core stays in its execute phase with nothing changed until a byte is present. It then pops that byte, zero-extends it into a register and carries on. Firmware therefore waits for bus data without polling a status register.

Instruction word layout: bits [15:12] hold the opcode, bits [11:10] hold field A (destination or tested register), bits [9:8] hold field B (source or base register) and bits [7:0] hold an 8-bit immediate `k`, sign-extended where it is used.

Top module: `tinycpu_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `imem_addr` is 0 and `dmem_we` and `fifo_pop` are low. All four registers read as 0 after reset.
- R2: Every instruction except a stalled receive-byte takes exactly two clocks, a fetch and then an execute. The address of instruction n appears on `imem_addr` for two cycles. A store asserts `dmem_we` for exactly one cycle, in its execute cycle.
- R3: ADD (opcode 0x0) writes A+B modulo 2^16 into A. AND (0x1) writes A&B into A.
- R4: SLT (0x2) writes 1 into A when A is less than B as signed two's-complement values, and writes 0 otherwise.
- R5: NOT (0x3) writes the bitwise complement of B into A. SR (0x4) writes B shifted right by one place with a zero shifted in into A.
- R6: LD (0x5) writes `dmem_rdata` into A. ST (0x6) drives A on `dmem_wdata`. Both use the address B + sext(k) modulo 2^16.
- R7: LDA (0x7) writes sext(k) into A.
- R8: BZ (0x8) sets the PC to PC+1+sext(k) when A is zero and to PC+1 otherwise. A negative offset branches backwards, and k = -1 branches to itself.
- R9: BAL (0x9) writes PC+1, zero-extended, into A and jumps to the low PC bits of B + sext(k), using the value B had before the write.
- R10: While the FIFO is empty, the receive-byte instruction (0xA) keeps `fifo_pop` low and holds the PC, the registers and data memory unchanged. In the first execute cycle with data it pulses `fifo_pop` for one cycle and writes {8'h00, `fifo_data`} into A.
- R11: Opcodes 0xB to 0xF change no register and no memory, and only advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W (8) | Instruction address, registered program counter |
| imem_rdata | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | DW (16) | Data address for loads and stores |
| dmem_wdata | output | DW (16) | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | DW (16) | Load data at `dmem_addr`, same cycle |
| fifo_empty | input | 1 | Receive FIFO has no byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_pop | output | 1 | Consume the head byte at this clock edge |

## Verification
The assertions assume a well-behaved FIFO. `fifo_empty` is a clean level that is valid in every cycle, and the head byte only advances on a clock edge where `fifo_pop` is high. They also assume that the instruction and data memories answer within the same cycle. The bench meets these assumptions with a push/pop-counter FIFO model and combinational-read memory arrays, and it pushes bytes only between clock edges. Random operands are loaded through LD so that the full 16-bit range, including sign boundaries, reaches the arithmetic instructions.

// File: rtl/tinycpu_pkg.sv
package tinycpu_pkg;
  localparam logic [3:0] OP_ADD = 4'h0;
  localparam logic [3:0] OP_AND = 4'h1;
  localparam logic [3:0] OP_SLT = 4'h2;
  localparam logic [3:0] OP_NOT = 4'h3;
  localparam logic [3:0] OP_SR  = 4'h4;
  localparam logic [3:0] OP_LD  = 4'h5;
  localparam logic [3:0] OP_ST  = 4'h6;
  localparam logic [3:0] OP_LDA = 4'h7;
  localparam logic [3:0] OP_BZ  = 4'h8;
  localparam logic [3:0] OP_BAL = 4'h9;
  localparam logic [3:0] OP_TAG = 4'hA;

  typedef enum logic {PH_FETCH = 1'b0, PH_EXEC = 1'b1} phase_e;

  typedef struct packed {
    logic [3:0] op;
    logic [1:0] ra;
    logic [1:0] rb;
    logic [7:0] k;
  } instr_t;
endpackage

// File: rtl/tinycpu_regfile.sv
module tinycpu_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_sel,
  input  logic [AW-1:0] rb_sel,
  output logic [DW-1:0] ra_val,
  output logic [DW-1:0] rb_val,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_sel,
  input  logic [DW-1:0] wr_val
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs_q[g] <= '0;
      else if (wr_en && wr_sel == AW'(g)) regs_q[g] <= wr_val;
    end
  end

  assign ra_val = regs_q[ra_sel];
  assign rb_val = regs_q[rb_sel];
endmodule

// File: rtl/tinycpu_result.sv
module tinycpu_result
  import tinycpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] load_data,
  input  logic [7:0]    rx_byte,
  input  logic [DW-1:0] link,
  output logic [DW-1:0] result,
  output logic          writes
);
  always_comb begin
    result = '0;
    writes = 1'b1;
    unique case (op)
      OP_ADD: result = a + b;
      OP_AND: result = a & b;
      OP_SLT: result = ($signed(a) < $signed(b)) ? DW'(1) : '0;
      OP_NOT: result = ~b;
      OP_SR:  result = b >> 1;
      OP_LD:  result = load_data;
      OP_LDA: result = imm;
      OP_BAL: result = link;
      OP_TAG: result = DW'(rx_byte);
      default: writes = 1'b0;
    endcase
  end
endmodule

// File: rtl/tinycpu_pcgen.sv
module tinycpu_pcgen
  import tinycpu_pkg::*;
#(
  parameter int PC_W = 8,
  parameter int DW   = 16
) (
  input  logic [3:0]      op,
  input  logic [PC_W-1:0] pc,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [DW-1:0]   imm,
  output logic [PC_W-1:0] pc_inc,
  output logic [PC_W-1:0] pc_next
);
  logic [DW-1:0] jump_target;

  assign pc_inc      = pc + 1'b1;
  assign jump_target = b + imm;

  always_comb begin
    pc_next = pc_inc;
    if (op == OP_BZ && a == '0) pc_next = pc_inc + imm[PC_W-1:0];
    else if (op == OP_BAL)      pc_next = jump_target[PC_W-1:0];
  end
endmodule

// File: rtl/tinycpu_core.sv
module tinycpu_core
  import tinycpu_pkg::*;
#(
  parameter int PC_W = 8,
  parameter int DW   = 16,
  parameter int NREG = 4
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] imem_addr,
  input  logic [15:0]     imem_rdata,
  output logic [DW-1:0]   dmem_addr,
  output logic [DW-1:0]   dmem_wdata,
  output logic            dmem_we,
  input  logic [DW-1:0]   dmem_rdata,
  input  logic            fifo_empty,
  input  logic [7:0]      fifo_data,
  output logic            fifo_pop
);
  localparam int KW = 8;
  localparam int RW = $clog2(NREG);

  phase_e          phase_q;
  logic [PC_W-1:0] pc_q;
  instr_t          ir_q;

  logic            in_exec;
  logic [3:0]      ir_op;
  logic            stall;
  logic [DW-1:0]   ra_val, rb_val, imm_sx, wb_val, link_val;
  logic            wb_kind;
  logic [PC_W-1:0] pc_inc, pc_next;

  assign in_exec  = (phase_q == PH_EXEC);
  assign ir_op    = ir_q.op;
  assign stall    = in_exec && ir_op == OP_TAG && fifo_empty;
  assign imm_sx   = {{(DW-KW){ir_q.k[KW-1]}}, ir_q.k};
  assign link_val = {{(DW-PC_W){1'b0}}, pc_inc};

  tinycpu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .ra_sel (RW'(ir_q.ra)),
    .rb_sel (RW'(ir_q.rb)),
    .ra_val (ra_val),
    .rb_val (rb_val),
    .wr_en  (in_exec && wb_kind && !stall),
    .wr_sel (RW'(ir_q.ra)),
    .wr_val (wb_val)
  );

  tinycpu_result #(.DW(DW)) u_res (
    .op        (ir_op),
    .a         (ra_val),
    .b         (rb_val),
    .imm       (imm_sx),
    .load_data (dmem_rdata),
    .rx_byte   (fifo_data),
    .link      (link_val),
    .result    (wb_val),
    .writes    (wb_kind)
  );

  tinycpu_pcgen #(.PC_W(PC_W), .DW(DW)) u_pc (
    .op      (ir_op),
    .pc      (pc_q),
    .a       (ra_val),
    .b       (rb_val),
    .imm     (imm_sx),
    .pc_inc  (pc_inc),
    .pc_next (pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
    end else if (!in_exec) begin
      ir_q    <= instr_t'(imem_rdata);
      phase_q <= PH_EXEC;
    end else if (!stall) begin
      pc_q    <= pc_next;
      phase_q <= PH_FETCH;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = rb_val + imm_sx;
  assign dmem_wdata = ra_val;
  assign dmem_we    = in_exec && ir_op == OP_ST;
  assign fifo_pop   = in_exec && ir_op == OP_TAG && !fifo_empty;
endmodule

// File: rtl/tinycpu_core_chk.sv
module tinycpu_core_chk #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_exec,
  input logic [3:0]      ir_op,
  input logic [PC_W-1:0] imem_addr,
  input logic            dmem_we,
  input logic            fifo_empty,
  input logic            fifo_pop
);
  a_r1_start_at_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (imem_addr == '0 && !in_exec && !dmem_we && !fifo_pop));

  a_r2_fetch_then_exec: assert property (@(posedge clk) disable iff (rst)
    !in_exec |=> in_exec);

  a_r2_store_one_cycle: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> !dmem_we);

  a_r2_pc_held_in_fetch: assert property (@(posedge clk) disable iff (rst)
    !in_exec |=> $stable(imem_addr));

  a_r10_pop_needs_byte: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);

  a_r10_pop_one_cycle: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop);

  a_r10_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (in_exec && ir_op == 4'hA && fifo_empty) |=> (in_exec && $stable(imem_addr)));

  a_r2_no_store_with_pop: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && fifo_pop));
endmodule

bind tinycpu_core tinycpu_core_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_exec    (in_exec),
  .ir_op      (ir_op),
  .imem_addr  (imem_addr),
  .dmem_we    (dmem_we),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop)
);

// File: tb/tb_tinycpu_core.sv
module tb_tinycpu_core;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imem_addr;
  logic [15:0] imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, fifo_empty, fifo_pop;
  logic [7:0]  fifo_data;

  logic [15:0] imem [0:255];
  logic [15:0] dmem [0:255];
  logic        pre_en = 1'b0;
  logic [7:0]  pre_addr = '0;
  logic [15:0] pre_data = '0;
  logic [7:0]  fbuf [0:15];
  int          push_n = 0;
  int          pop_n = 0;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  tinycpu_core dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop)
  );

  assign imem_rdata = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr[7:0]];
  assign fifo_empty = (push_n == pop_n);
  assign fifo_data  = fbuf[pop_n[3:0]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
    else if (pre_en) dmem[pre_addr] <= pre_data;
    if (fifo_pop) pop_n <= pop_n + 1;
  end

  function automatic logic [15:0] enc(int op, int ra, int rb, int k);
    return {op[3:0], ra[1:0], rb[1:0], k[7:0]};
  endfunction

  function automatic logic [15:0] model(int op, logic [15:0] a, logic [15:0] b);
    case (op)
      0: return a + b;
      1: return a & b;
      2: return ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
      3: return ~b;
      default: return {1'b0, b[15:1]};
    endcase
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic preload(int addr, logic [15:0] val);
    @(negedge clk);
    pre_en = 1'b1; pre_addr = addr[7:0]; pre_data = val;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic clear_prog();
    rst = 1'b1;
    for (int i = 0; i < 256; i++) imem[i] = enc(8, 3, 0, -1);
  endtask

  task automatic release_run(int n);
    @(negedge clk);
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic push_byte(logic [7:0] v);
    fbuf[push_n % 16] = v;
    push_n++;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base_pops;
    repeat (3) @(negedge clk);

    // R1: reset state, and all registers read as zero afterwards
    clear_prog();
    check("R1 reset imem_addr", 16'(imem_addr), 16'h0);
    check("R1 reset dmem_we", 16'(dmem_we), 16'h0);
    check("R1 reset fifo_pop", 16'(fifo_pop), 16'h0);
    imem[0] = enc(6, 0, 3, 8'h30);
    imem[1] = enc(6, 1, 2, 8'h31);
    imem[2] = enc(6, 2, 3, 8'h32);
    imem[3] = enc(6, 3, 0, 8'h33);
    for (int i = 0; i < 4; i++) preload(8'h30 + i, 16'hFFFF);
    release_run(20);
    for (int i = 0; i < 4; i++) check("R1 register zero after reset", dmem[8'h30 + i], 16'h0);

    // R2: two clocks per instruction, one-cycle store strobe
    clear_prog();
    imem[0] = enc(7, 0, 0, 5);
    imem[1] = enc(6, 0, 3, 8'h40);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 6; k++) begin
      check("R2 fetch address per cycle", 16'(imem_addr), 16'(k / 2));
      check("R2 store strobe timing", 16'(dmem_we), (k == 3) ? 16'h1 : 16'h0);
      @(negedge clk);
    end
    check("R2 R7 stored immediate", dmem[8'h40], 16'h0005);

    // R3 R4 R5 R6: random and corner operands through LD/op/ST
    begin
      logic [15:0] corner [0:5];
      corner[0] = 16'h7FFF; corner[1] = 16'h8000; corner[2] = 16'hFFFF;
      corner[3] = 16'h0000; corner[4] = 16'h0001; corner[5] = 16'h8001;
      void'($urandom(32'h5EED1234));
      for (int t = 0; t < 60; t++) begin
        int op;
        logic [15:0] a, b;
        op = t % 5;
        a = (t < 30) ? 16'($urandom) : corner[$urandom % 6];
        b = (t < 30) ? 16'($urandom) : corner[$urandom % 6];
        clear_prog();
        imem[0] = enc(7, 3, 0, 0);
        imem[1] = enc(5, 0, 3, 8'h10);
        imem[2] = enc(5, 1, 3, 8'h11);
        imem[3] = enc(op, 0, 1, 0);
        imem[4] = enc(6, 0, 3, 8'h20);
        preload(8'h10, a);
        preload(8'h11, b);
        preload(8'h20, 16'hDEAD);
        release_run(16);
        case (op)
          0, 1: check("R3 R6 add/and result", dmem[8'h20], model(op, a, b));
          2:    check("R4 R6 signed compare", dmem[8'h20], model(op, a, b));
          default: check("R5 R6 not/shift result", dmem[8'h20], model(op, a, b));
        endcase
      end
    end

    // R6: negative displacement on load and store
    clear_prog();
    imem[0] = enc(7, 2, 0, 8'h50);
    imem[1] = enc(5, 1, 2, -2);
    imem[2] = enc(6, 1, 2, -1);
    preload(8'h4E, 16'hBEEF);
    preload(8'h4F, 16'h0000);
    release_run(16);
    check("R6 negative displacement", dmem[8'h4F], 16'hBEEF);

    // R7 R8 R9 R11: control flow and unused opcode
    clear_prog();
    imem[0]  = enc(7, 0, 0, 0);
    imem[1]  = enc(8, 0, 0, 2);
    imem[2]  = enc(7, 1, 0, 1);
    imem[3]  = enc(6, 1, 3, 8'h50);
    imem[4]  = enc(7, 1, 0, 7);
    imem[5]  = enc(8, 1, 0, 5);
    imem[6]  = enc(9, 2, 3, 10);
    imem[7]  = enc(6, 1, 3, 8'h50);
    imem[10] = enc(6, 2, 3, 8'h51);
    imem[11] = enc(6, 1, 3, 8'h52);
    imem[12] = enc(7, 0, 0, -3);
    imem[13] = enc(6, 0, 3, 8'h53);
    imem[14] = enc(11, 1, 0, 8'hFF);
    imem[15] = enc(6, 1, 3, 8'h54);
    preload(8'h50, 16'hAAAA);
    release_run(60);
    check("R8 taken branch skipped store", dmem[8'h50], 16'hAAAA);
    check("R9 link value", dmem[8'h51], 16'h0007);
    check("R8 untaken branch fell through", dmem[8'h52], 16'h0007);
    check("R7 sign-extended immediate", dmem[8'h53], 16'hFFFD);
    check("R11 unused opcode no effect", dmem[8'h54], 16'h0007);
    check("R8 branch to self holds PC", 16'(imem_addr), 16'd16);

    // R10: blocking receive-byte
    clear_prog();
    imem[0] = enc(10, 0, 0, 0);
    imem[1] = enc(6, 0, 3, 8'h60);
    imem[2] = enc(10, 1, 0, 0);
    imem[3] = enc(6, 1, 3, 8'h61);
    preload(8'h60, 16'h1234);
    preload(8'h61, 16'h1234);
    base_pops = pop_n;
    release_run(30);
    check("R10 stalled PC", 16'(imem_addr), 16'h0);
    check("R10 no pop while empty", 16'(pop_n - base_pops), 16'h0);
    check("R10 no store while stalled", dmem[8'h60], 16'h1234);
    push_byte(8'hC5);
    repeat (8) @(negedge clk);
    check("R10 byte zero-extended", dmem[8'h60], 16'h00C5);
    check("R10 one pop per byte", 16'(pop_n - base_pops), 16'h1);
    check("R10 second stall PC", 16'(imem_addr), 16'h2);
    push_byte(8'h80);
    repeat (8) @(negedge clk);
    check("R10 high byte zero-extended", dmem[8'h61], 16'h0080);
    check("R10 total pops", 16'(pop_n - base_pops), 16'h2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule